// File: doc/BRIEF.md
# Two-Rail Soft-Start and Fault Retry Sequencer

This block is the digital controller that brings a two-rail regulator up and protects it. One rail is a switching converter and the other a linear regulator. Both are started from a single soft-start ramp. Once the input-present indication arrives and the disable input is low, the block enables both rails and produces a reference code. That code rises by one step every `STEP_CYCLES` clocks and is clamped at the nominal reference `NOM_REF`.

The ramp runs to its full scale of all ones. After that, the block arms two undervoltage qualifiers, one per feedback input. Each qualifier reports a fault only after its flag has been high for `UV_DLY` consecutive clocks. An overcurrent flag counts only while the low-side switch conducts, and it is honoured during both the ramp and steady operation.

Each fault drops both enables and zeroes the reference. The block then holds off for one full ramp period before restarting from code zero. The fault that brings the count to `HICCUP_LIMIT` instead latches both rails off. The fault count and the latch clear only on reset or when the disable input is asserted.

Top module: `softstart_hiccup_seq`

## Requirements
- R1: While `rst_n` is low, and at the first sample after its release, `sw_en`, `lin_en` and `ref_code` are all 0.
- R2: From the idle state, the rails stay off while `in_ok` is 0. They enable on the clock after `in_ok`=1 is sampled with `dis`=0, and the ramp starts at code 0.
- R3: Let k be the number of clocks since the enables rose. While enabled, `ref_code` equals min(floor(k/`STEP_CYCLES`), `NOM_REF`). The internal ramp stops at 2^`CODE_W`-1.
- R4: `lin_en` equals `sw_en` in every cycle, so the linear rail shares the same ramp.
- R5: Undervoltage flags have no effect until the ramp has reached full scale.
- R6: After full scale, an undervoltage flag (`uv_sw` or `uv_lin`) held high for `UV_DLY` consecutive clocks causes a fault on the `UV_DLY`-th clock. A flag held for fewer clocks has no effect.
- R7: `oc_flag` causes a fault on the next clock only when `lowside_on` is 1 in the same cycle. With `lowside_on`=0 it is ignored.
- R8: For a non-final fault, both enables and `ref_code` are 0 for exactly (2^`CODE_W`-1)*`STEP_CYCLES` clocks. The block then re-enables with `ref_code` restarting from 0, provided `in_ok` is 1.
- R9: The `HICCUP_LIMIT`-th fault since reset or the last disable latches both enables off, and they stay off while `in_ok` stays 1.
- R10: `dis`=1 forces both enables low on the next clock and keeps them low. It also clears the fault count and the latch, so releasing it with `in_ok`=1 restarts the ramp on the following clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_ok | input | 1 | Switching input supply detected |
| dis | input | 1 | Disable, high turns both rails off |
| lowside_on | input | 1 | Low-side switch currently conducting |
| oc_flag | input | 1 | Overcurrent comparator output |
| uv_sw | input | 1 | Switching feedback below half reference |
| uv_lin | input | 1 | Linear feedback below half reference |
| ref_code | output | CODE_W | Effective reference code to the DAC |
| sw_en | output | 1 | Switching channel enable |
| lin_en | output | 1 | Linear channel enable |

## Verification
The bench sweeps the whole ramp cycle by cycle against min(floor(k/STEP), NOM). It does this with undervoltage held high throughout, and with overcurrent high while the low side is off. A design that armed undervoltage too early, or that ignored the low-side qualifier, would drop its enables in the middle of the ramp.

It checks undervoltage pulses one clock shorter than the delay and exactly equal to it. It also measures every off window to the exact clock count. Together these expose an off-by-one qualifier or a cool-down that is too short.

Faults are counted through a full set of `HICCUP_LIMIT` retries, both from reset and again after a disable cycle. A counter that is not cleared by disable, or that latches one fault early or late, would show up as a wrong off length or as a rail that never returns.

// File: rtl/sshq_pkg.sv
`timescale 1ns/1ps
package sshq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RAMP = 3'd1,
        ST_RUN  = 3'd2,
        ST_COOL = 3'd3,
        ST_LOCK = 3'd4
    } seq_state_e;
endpackage

// File: rtl/ss_ramp.sv
`timescale 1ns/1ps
module ss_ramp #(
    parameter int CODE_W      = 10,
    parameter int STEP_CYCLES = 1955
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              adv_i,
    output logic [CODE_W-1:0] code_o,
    output logic              full_o
);
    localparam int PRE_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] CODE_ONE = {{(CODE_W-1){1'b0}}, 1'b1};
    localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(STEP_CYCLES - 1);

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [CODE_W-1:0] code;
    } ramp_t;

    ramp_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr_i) begin
            r_d.pre  = '0;
            r_d.code = '0;
        end else if (adv_i && (r_q.code != CODE_MAX)) begin
            if (r_q.pre == PRE_LAST) begin
                r_d.pre  = '0;
                r_d.code = r_q.code + CODE_ONE;
            end else begin
                r_d.pre = r_q.pre + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign code_o = r_q.code;
    assign full_o = (r_q.code == CODE_MAX);

    AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !clr_i) |=> ((code_o == $past(code_o)) || (code_o == $past(code_o) + CODE_ONE))); // R3
endmodule

// File: rtl/uv_qual.sv
`timescale 1ns/1ps
module uv_qual #(
    parameter int DLY = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic uv_i,
    output logic fault_o
);
    localparam int CW = $clog2(DLY + 1);
    localparam logic [CW-1:0] CNT_TRIP = CW'(DLY - 1);
    localparam logic [CW-1:0] CNT_SAT  = CW'(DLY);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!arm_i || !uv_i)       cnt_d = '0;
        else if (cnt_q != CNT_SAT) cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign fault_o = arm_i && uv_i && (cnt_q == CNT_TRIP);

    generate
        if (DLY > 1) begin : g_chk
            AST_UV_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
                fault_o |-> ($past(uv_i) && $past(arm_i))); // R6
        end
    endgenerate
endmodule

// File: rtl/softstart_hiccup_seq.sv
`timescale 1ns/1ps
module softstart_hiccup_seq
    import sshq_pkg::*;
#(
    parameter int CODE_W       = 10,
    parameter int NOM_REF      = 512,
    parameter int STEP_CYCLES  = 1955,
    parameter int UV_DLY       = 3000,
    parameter int HICCUP_LIMIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_ok,
    input  logic              dis,
    input  logic              lowside_on,
    input  logic              oc_flag,
    input  logic              uv_sw,
    input  logic              uv_lin,
    output logic [CODE_W-1:0] ref_code,
    output logic              sw_en,
    output logic              lin_en
);
    localparam int NUM_UV     = 2;
    localparam int OFF_CYCLES = ((2 ** CODE_W) - 1) * STEP_CYCLES;
    localparam int OFF_W      = $clog2(OFF_CYCLES + 1);
    localparam int HC_W       = $clog2(HICCUP_LIMIT + 1);
    localparam logic [OFF_W-1:0]  OFF_LAST = OFF_W'(OFF_CYCLES - 1);
    localparam logic [HC_W-1:0]   HC_LAST  = HC_W'(HICCUP_LIMIT - 1);
    localparam logic [HC_W-1:0]   HC_MAX   = HC_W'(HICCUP_LIMIT);
    localparam logic [CODE_W-1:0] NOM_C    = CODE_W'(NOM_REF);

    typedef struct packed {
        seq_state_e       st;
        logic [HC_W-1:0]  hic;
        logic [OFF_W-1:0] off;
    } ctl_t;

    ctl_t c_d, c_q;

    logic              active;
    logic              ramp_clr;
    logic              ramp_adv;
    logic [CODE_W-1:0] ramp_code;
    logic              ramp_full;
    logic              uv_arm;
    logic [NUM_UV-1:0] uv_vec;
    logic [NUM_UV-1:0] uv_fault;
    logic              uv_any;
    logic              oc_hit;
    logic              fault_any;

    assign active   = (c_q.st == ST_RAMP) || (c_q.st == ST_RUN);
    assign ramp_clr = !active;
    assign ramp_adv = (c_q.st == ST_RAMP);
    assign uv_arm   = (c_q.st == ST_RUN);
    assign uv_vec   = {uv_lin, uv_sw};

    ss_ramp #(
        .CODE_W      (CODE_W),
        .STEP_CYCLES (STEP_CYCLES)
    ) u_ramp (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (ramp_clr),
        .adv_i  (ramp_adv),
        .code_o (ramp_code),
        .full_o (ramp_full)
    );

    generate
        for (genvar g = 0; g < NUM_UV; g++) begin : g_uv
            uv_qual #(
                .DLY (UV_DLY)
            ) u_uv (
                .clk     (clk),
                .rst_n   (rst_n),
                .arm_i   (uv_arm),
                .uv_i    (uv_vec[g]),
                .fault_o (uv_fault[g])
            );
        end
    endgenerate

    assign uv_any    = |uv_fault;
    assign oc_hit    = active && lowside_on && oc_flag;
    assign fault_any = uv_any || oc_hit;

    always_comb begin
        c_d = c_q;
        unique case (c_q.st)
            ST_IDLE: begin
                if (in_ok) c_d.st = ST_RAMP;
            end
            ST_RAMP, ST_RUN: begin
                if (fault_any) begin
                    c_d.off = '0;
                    if (c_q.hic == HC_LAST) begin
                        c_d.hic = HC_MAX;
                        c_d.st  = ST_LOCK;
                    end else begin
                        c_d.hic = c_q.hic + HC_W'(1);
                        c_d.st  = ST_COOL;
                    end
                end else if ((c_q.st == ST_RAMP) && ramp_full) begin
                    c_d.st = ST_RUN;
                end
            end
            ST_COOL: begin
                if (c_q.off == OFF_LAST) begin
                    c_d.off = '0;
                    c_d.st  = in_ok ? ST_RAMP : ST_IDLE;
                end else begin
                    c_d.off = c_q.off + OFF_W'(1);
                end
            end
            ST_LOCK: begin
                c_d.st = ST_LOCK;
            end
            default: begin
                c_d.st = ST_IDLE;
            end
        endcase
        if (dis) begin
            c_d.st  = ST_IDLE;
            c_d.hic = '0;
            c_d.off = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st  <= ST_IDLE;
            c_q.hic <= '0;
            c_q.off <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign sw_en    = active;
    assign lin_en   = active;
    assign ref_code = !active ? '0 : ((ramp_code < NOM_C) ? ramp_code : NOM_C);

    AST_DIS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        dis |=> (!sw_en && !lin_en)); // R10
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.st == ST_LOCK) && !dis) |=> (c_q.st == ST_LOCK)); // R9
    AST_HIC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.hic <= HC_MAX); // R9
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_en) |-> (ref_code == '0)); // R8
    AST_OC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.st == ST_RUN) && !lowside_on && !uv_any && !dis) |=> (c_q.st == ST_RUN)); // R7
    AST_UV_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.st == ST_RAMP) && !oc_hit && !dis) |=> sw_en); // R5
endmodule

// File: tb/tb_softstart_hiccup_seq.sv
`timescale 1ns/1ps
module tb_softstart_hiccup_seq;
    localparam int CODE_W = 6;
    localparam int NOM    = 40;
    localparam int STEP   = 2;
    localparam int UVD    = 4;
    localparam int LIMIT  = 4;
    localparam int OFFN   = ((2 ** CODE_W) - 1) * STEP;
    localparam int CAP    = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_ok = 1'b0, dis = 1'b0, lowside_on = 1'b0, oc_flag = 1'b0;
    logic uv_sw = 1'b0, uv_lin = 1'b0;
    logic [CODE_W-1:0] ref_code;
    logic sw_en, lin_en;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    softstart_hiccup_seq #(
        .CODE_W (CODE_W), .NOM_REF (NOM), .STEP_CYCLES (STEP),
        .UV_DLY (UVD), .HICCUP_LIMIT (LIMIT)
    ) dut (
        .clk (clk), .rst_n (rst_n), .in_ok (in_ok), .dis (dis),
        .lowside_on (lowside_on), .oc_flag (oc_flag), .uv_sw (uv_sw), .uv_lin (uv_lin),
        .ref_code (ref_code), .sw_en (sw_en), .lin_en (lin_en)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (!sw_en && n < CAP) begin
            n++;
            tick();
        end
    endtask

    task automatic oc_pulse();
        lowside_on = 1'b1; oc_flag = 1'b1;
        tick();
        lowside_on = 1'b0; oc_flag = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        int hi;
        repeat (3) tick();
        chk(!sw_en && !lin_en && ref_code == 0, "R1 in reset", int'(sw_en), 0);
        rst_n = 1'b1;
        tick();
        chk(!sw_en && !lin_en && ref_code == 0, "R1 after reset", int'(ref_code), 0);

        hi = 0;
        repeat (5) begin tick(); if (sw_en) hi++; end
        chk(hi == 0, "R2 no start without in_ok", hi, 0);

        // full ramp sweep with UV high (R5) and OC high with low side off (R7)
        in_ok = 1'b1; uv_sw = 1'b1; uv_lin = 1'b1; oc_flag = 1'b1;
        tick();
        for (int k = 0; k <= 140; k++) begin
            int e;
            e = (k / STEP < NOM) ? k / STEP : NOM;
            chk(int'(ref_code) == e, "R3 ramp code", int'(ref_code), e);
            chk(sw_en && lin_en, "R4 R5 R7 both enables on", int'(sw_en) + int'(lin_en), 2);
            if (k == 120) begin uv_sw = 1'b0; uv_lin = 1'b0; end
            tick();
        end
        oc_flag = 1'b0;

        // short UV glitch
        uv_sw = 1'b1;
        repeat (UVD - 1) tick();
        uv_sw = 1'b0;
        hi = 0;
        repeat (6) begin if (sw_en) hi++; tick(); end
        chk(hi == 6, "R6 short UV ignored", hi, 6);

        // qualified UV on linear channel: fault 1
        uv_lin = 1'b1;
        repeat (UVD - 1) tick();
        chk(sw_en, "R6 still on before delay", int'(sw_en), 1);
        tick();
        chk(!sw_en && !lin_en && ref_code == 0, "R6 UV fault", int'(sw_en), 0);
        uv_lin = 1'b0;
        count_low(n);
        chk(n == OFFN, "R8 off window after UV", n, OFFN);
        chk(ref_code == 0 && lin_en, "R8 restart at zero", int'(ref_code), 0);

        // OC fault 2 in run state
        repeat (140) tick();
        oc_pulse();
        chk(!sw_en, "R7 OC with low side on", int'(sw_en), 0);
        count_low(n);
        chk(n == OFFN, "R8 off window after OC", n, OFFN);

        // OC fault 3 during ramp
        repeat (5) tick();
        oc_pulse();
        count_low(n);
        chk(n == OFFN, "R8 off window ramp fault", n, OFFN);

        // fault 4 latches
        repeat (3) tick();
        oc_pulse();
        count_low(n);
        chk(n == CAP, "R9 latched off", n, CAP);
        chk(ref_code == 0, "R9 ref zero when latched", int'(ref_code), 0);

        // disable cycle clears latch and count
        dis = 1'b1;
        tick();
        chk(!sw_en && !lin_en, "R10 off while disabled", int'(sw_en), 0);
        dis = 1'b0;
        tick();
        chk(sw_en && ref_code == 0, "R10 restart after release", int'(sw_en), 1);
        for (int f = 1; f <= LIMIT; f++) begin
            repeat (3) tick();
            oc_pulse();
            count_low(n);
            if (f < LIMIT) chk(n == OFFN, "R10 count cleared, retry", n, OFFN);
            else           chk(n == CAP, "R9 limit reached again", n, CAP);
        end

        // disable during run
        dis = 1'b1; tick(); dis = 1'b0; tick();
        repeat (140) tick();
        chk(sw_en, "R10 running before disable", int'(sw_en), 1);
        dis = 1'b1;
        tick();
        chk(!sw_en && !lin_en, "R10 disable drops enables", int'(sw_en), 0);
        hi = 0;
        repeat (50) begin if (sw_en) hi++; tick(); end
        chk(hi == 0, "R10 held off while disabled", hi, 0);
        dis = 1'b0;
        tick();
        chk(sw_en && ref_code == 0, "R10 resumes", int'(sw_en), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule